// File: doc/BRIEF.md
# Clock Stop and Wakeup Controller

This block decides when the CPU core clock and the system clock may be gated off, and how the chip comes back. Software asks for a stop with a one-cycle request and picks its depth. The light stop gates only the core clock, so the system clock and every timer keep running. The deep stop gates the system clock as well, which also takes the core down. In the deep stop, the watchdog clock and the real-time timer clock each stay on only if their own keep-running bit is set.

The controller runs on an always-on clock, so it keeps watching wake sources while the system clock is off. Wake sources fall into two classes. A port interrupt line or a real-time timer interrupt restores the clocks and gives a one-cycle resume pulse, and execution carries on from where it stopped. A watchdog overflow, a brown-out event or a low level on the external reset pin gives a reset request instead. That request turns every clock back on and is held for a minimum time.

All wake inputs pass through the same synchronizer. A source therefore acts on the third rising clock edge after it changes. The gate enables are registered, so a gating cell sees a clean level.

Top module: `clkstop_ctrl`

## Requirements
- R1: After `rst_ni` is released, all four clock enables are 1, and `resume_o` and `rst_req_o` are 0.
- R2: A stop request with `stop_deep_i`=0 clears `core_clk_en_o` on the edge that samples the request. `sys_clk_en_o`, `wdt_clk_en_o` and `rtt_clk_en_o` stay 1.
- R3: A stop request with `stop_deep_i`=1 clears both `core_clk_en_o` and `sys_clk_en_o` on the sampling edge. `wdt_clk_en_o` then equals `wdt_keep_i` and `rtt_clk_en_o` equals `rtt_keep_i`.
- R4: While stopped, a high level on any `port_irq_i` bit or on `rtt_irq_i` acts on the third rising edge after it is applied. On that edge all enables return to 1, `resume_o` pulses for exactly one cycle, and `rst_req_o` stays 0.
- R5: A high `wdt_ovf_i`, a high `bor_i` or a low `rst_pin_ni` raises `rst_req_o` on the third rising edge after it is applied, whether or not the block is stopped. While `rst_req_o` is 1, all enables are 1 and `resume_o` is 0.
- R6: If a reset source is seen for M consecutive synchronized cycles, `rst_req_o` stays high for M+`RST_HOLD_CYC`-1 cycles, and never for fewer than `RST_HOLD_CYC` cycles.
- R7: A stop request is cancelled when a synchronized resume source is high on the same edge. The enables stay 1 and no resume pulse is given.
- R8: A stop request that arrives while the block is already stopped has no effect. In particular, it cannot deepen a light stop.
- R9: When a reset source and a resume source arrive together during a stop, the reset wins: `rst_req_o` rises and `resume_o` stays 0.
- R10: Resume sources that arrive while the block is running give no resume pulse and leave every enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| stop_req_i | input | 1 | One-cycle stop request from software |
| stop_deep_i | input | 1 | Stop depth: 0 = core only, 1 = system clock |
| wdt_keep_i | input | 1 | Keep the watchdog clock on during a deep stop |
| rtt_keep_i | input | 1 | Keep the real-time timer clock on during a deep stop |
| port_irq_i | input | IRQ_W | External port interrupt lines |
| rtt_irq_i | input | 1 | Real-time timer interrupt |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| bor_i | input | 1 | Brown-out detected |
| rst_pin_ni | input | 1 | External reset pin, active low |
| core_clk_en_o | output | 1 | CPU core clock gate enable |
| sys_clk_en_o | output | 1 | System clock gate enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| rtt_clk_en_o | output | 1 | Real-time timer clock enable |
| resume_o | output | 1 | One-cycle pulse: clocks restored without reset |
| rst_req_o | output | 1 | Chip reset request |

## Verification
Two things can meet on the same clock edge: a software stop request and a wake event, or a resuming wake and a resetting wake. The bench provokes the first case by applying a port interrupt two edges ahead of the stop request, so that both reach the state logic together. It then expects the clocks to stay on with no resume pulse. It provokes the second case by raising a port interrupt and a brown-out in the same cycle during a deep stop. It then expects a reset request and no resume pulse.

// File: rtl/clkstop_pkg.sv
// Shared types for the clock stop and wakeup controller.
package clkstop_pkg;

    // Controller state; ST_RST_HOLD keeps the reset request asserted.
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_CORE_HALT = 2'd1,
        ST_SYS_HALT  = 2'd2,
        ST_RST_HOLD  = 2'd3
    } cs_state_e;

    // Decoded wake classes.
    typedef struct packed {
        logic resume;
        logic reset;
    } wake_cls_t;

endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage synchronizer for a vector of level inputs.
// Assumes: the inputs are levels held for at least one clk_i period; the
// reset value of every stage is 0 (no event).
module clkstop_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the previous stage.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkstop_classify.sv
// Sorts synchronized wake events into resume-in-place and reset classes.
// Assumes: vector layout {pin, bor, wdt, rtt, port[IRQ_W-1:0]}, active high.
module clkstop_classify
    import clkstop_pkg::*;
#(
    parameter int IRQ_W = 8,
    localparam int SRC_W = IRQ_W + 4
) (
    input  logic [SRC_W-1:0] src_i,
    output wake_cls_t        cls_o
);

    localparam int RTT_BIT = IRQ_W;
    localparam int WDT_BIT = IRQ_W + 1;
    localparam int BOR_BIT = IRQ_W + 2;
    localparam int PIN_BIT = IRQ_W + 3;

    // Combine each class with an OR reduction.
    always_comb begin
        cls_o.resume = (|src_i[IRQ_W-1:0]) | src_i[RTT_BIT];
        cls_o.reset  = src_i[WDT_BIT] | src_i[BOR_BIT] | src_i[PIN_BIT];
    end

endmodule

// File: rtl/clkstop_fsm.sv
// Stop/run state machine with the reset hold counter.
// Assumes: stop_req_i is synchronous to clk_i; wake classes are synchronized.
// A reset source has priority over everything; a resume source in the same
// cycle as a stop request cancels that request.
module clkstop_fsm
    import clkstop_pkg::*;
#(
    parameter int RST_HOLD_CYC = 4,
    localparam int CNT_W = $clog2(RST_HOLD_CYC) + 1
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      stop_req_i,
    input  logic      stop_deep_i,
    input  wake_cls_t cls_i,
    output cs_state_e state_nxt_o,
    output logic      resume_set_o
);

    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_HOLD_CYC - 1);

    cs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             resume_set;

    // Next-state and hold-counter decision.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        resume_set = 1'b0;
        if (cls_i.reset) begin
            state_d = ST_RST_HOLD;
            cnt_d   = HOLD_LOAD;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (stop_req_i && !cls_i.resume)
                        state_d = stop_deep_i ? ST_SYS_HALT : ST_CORE_HALT;
                end
                ST_CORE_HALT, ST_SYS_HALT: begin
                    if (cls_i.resume) begin
                        state_d    = ST_RUN;
                        resume_set = 1'b1;
                    end
                end
                ST_RST_HOLD: begin
                    if (cnt_q == '0) state_d = ST_RUN;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_nxt_o  = state_d;
    assign resume_set_o = resume_set;

endmodule

// File: rtl/clkstop_gate_reg.sv
// Registers every output from the next state so each gate enable is a
// single flop output, free of decode glitches.
// Assumes: a downstream gating cell latches its enable while its clock is low.
module clkstop_gate_reg
    import clkstop_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  cs_state_e state_nxt_i,
    input  logic      resume_set_i,
    input  logic      wdt_keep_i,
    input  logic      rtt_keep_i,
    output logic      core_en_o,
    output logic      sys_en_o,
    output logic      wdt_en_o,
    output logic      rtt_en_o,
    output logic      resume_o,
    output logic      rst_req_o
);

    logic sys_on;

    // The system clock is off only in the deep stop.
    always_comb sys_on = (state_nxt_i != ST_SYS_HALT);

    // Output flops loaded from the decoded next state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            core_en_o <= 1'b1;
            sys_en_o  <= 1'b1;
            wdt_en_o  <= 1'b1;
            rtt_en_o  <= 1'b1;
            resume_o  <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            core_en_o <= (state_nxt_i == ST_RUN) || (state_nxt_i == ST_RST_HOLD);
            sys_en_o  <= sys_on;
            wdt_en_o  <= sys_on || wdt_keep_i;
            rtt_en_o  <= sys_on || rtt_keep_i;
            resume_o  <= resume_set_i;
            rst_req_o <= (state_nxt_i == ST_RST_HOLD);
        end
    end

endmodule

// File: rtl/clkstop_ctrl.sv
// Top of the clock stop and wakeup controller.
// Assumes: clk_i is always on; all wake inputs may be asynchronous and pass
// through one shared synchronizer, SYNC_STAGES deep.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int IRQ_W        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int RST_HOLD_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_req_i,
    input  logic             stop_deep_i,
    input  logic             wdt_keep_i,
    input  logic             rtt_keep_i,
    input  logic [IRQ_W-1:0] port_irq_i,
    input  logic             rtt_irq_i,
    input  logic             wdt_ovf_i,
    input  logic             bor_i,
    input  logic             rst_pin_ni,
    output logic             core_clk_en_o,
    output logic             sys_clk_en_o,
    output logic             wdt_clk_en_o,
    output logic             rtt_clk_en_o,
    output logic             resume_o,
    output logic             rst_req_o
);

    localparam int SRC_W = IRQ_W + 4;

    logic [SRC_W-1:0] raw_src, sync_src;
    wake_cls_t        cls;
    cs_state_e        state_nxt;
    logic             resume_set;

    // Pack the wake sources, all active high.
    always_comb raw_src = {~rst_pin_ni, bor_i, wdt_ovf_i, rtt_irq_i, port_irq_i};

    clkstop_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_src),
        .q_o    (sync_src)
    );

    clkstop_classify #(.IRQ_W(IRQ_W)) i_cls (
        .src_i (sync_src),
        .cls_o (cls)
    );

    clkstop_fsm #(.RST_HOLD_CYC(RST_HOLD_CYC)) i_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stop_req_i   (stop_req_i),
        .stop_deep_i  (stop_deep_i),
        .cls_i        (cls),
        .state_nxt_o  (state_nxt),
        .resume_set_o (resume_set)
    );

    clkstop_gate_reg i_gate (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_nxt_i  (state_nxt),
        .resume_set_i (resume_set),
        .wdt_keep_i   (wdt_keep_i),
        .rtt_keep_i   (rtt_keep_i),
        .core_en_o    (core_clk_en_o),
        .sys_en_o     (sys_clk_en_o),
        .wdt_en_o     (wdt_clk_en_o),
        .rtt_en_o     (rtt_clk_en_o),
        .resume_o     (resume_o),
        .rst_req_o    (rst_req_o)
    );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
// Property checker for clkstop_ctrl, attached by bind.
module clkstop_ctrl_chk #(
    parameter int RST_HOLD_CYC = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic core_clk_en_o,
    input logic sys_clk_en_o,
    input logic wdt_clk_en_o,
    input logic rtt_clk_en_o,
    input logic resume_o,
    input logic rst_req_o
);

    logic [15:0] hi_len_q;

    // Length of the current run of rst_req_o, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                hi_len_q <= '0;
        else if (!rst_req_o)        hi_len_q <= '0;
        else if (hi_len_q != '1)    hi_len_q <= hi_len_q + 1'b1;
    end

    // R2
    core_stop_timers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_clk_en_o && !core_clk_en_o) |-> (wdt_clk_en_o && rtt_clk_en_o));

    // R3
    sys_off_core_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sys_clk_en_o |-> !core_clk_en_o);

    // R4
    resume_clocks_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resume_o |-> (core_clk_en_o && sys_clk_en_o));

    // R4
    resume_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resume_o |=> !resume_o);

    // R5
    reset_clocks_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> (core_clk_en_o && sys_clk_en_o && wdt_clk_en_o && rtt_clk_en_o));

    // R6
    reset_min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_req_o) |-> (hi_len_q >= 16'(RST_HOLD_CYC)));

    // R9
    reset_over_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(resume_o && rst_req_o));

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.RST_HOLD_CYC(RST_HOLD_CYC)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .core_clk_en_o (core_clk_en_o),
    .sys_clk_en_o  (sys_clk_en_o),
    .wdt_clk_en_o  (wdt_clk_en_o),
    .rtt_clk_en_o  (rtt_clk_en_o),
    .resume_o      (resume_o),
    .rst_req_o     (rst_req_o)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;

    localparam int IRQ_W = 8;
    localparam int HOLD  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_req = 1'b0, stop_deep = 1'b0;
    logic             wdt_keep = 1'b0, rtt_keep = 1'b0;
    logic [IRQ_W-1:0] port_irq = '0;
    logic             rtt_irq = 1'b0, wdt_ovf = 1'b0, bor = 1'b0, rst_pin_n = 1'b1;
    logic             core_en, sys_en, wdt_en, rtt_en, resume, rst_req;

    int checks = 0;
    int errors = 0;

    always #10ns clk = ~clk;

    clkstop_ctrl #(.IRQ_W(IRQ_W), .SYNC_STAGES(2), .RST_HOLD_CYC(HOLD)) i_clkstop_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .stop_deep_i(stop_deep),
        .wdt_keep_i(wdt_keep), .rtt_keep_i(rtt_keep), .port_irq_i(port_irq),
        .rtt_irq_i(rtt_irq), .wdt_ovf_i(wdt_ovf), .bor_i(bor), .rst_pin_ni(rst_pin_n),
        .core_clk_en_o(core_en), .sys_clk_en_o(sys_en), .wdt_clk_en_o(wdt_en),
        .rtt_clk_en_o(rtt_en), .resume_o(resume), .rst_req_o(rst_req)
    );

    // {mode, wdt_keep, rtt_keep, kind}; kind 0/1 port bit 0/7, 2 rtt, 3 wdt, 4 bor, 5 pin
    localparam int NV = 10;
    localparam logic [5:0] VECS [NV] = '{
        6'b0_1_1_000, 6'b1_0_0_001, 6'b1_1_0_010, 6'b1_0_1_011, 6'b0_1_1_100,
        6'b1_1_1_101, 6'b0_0_0_010, 6'b1_0_0_000, 6'b1_1_0_100, 6'b0_1_0_101
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_stop(input logic deep);
        stop_deep = deep;
        stop_req  = 1'b1;
        tick(1);
        stop_req  = 1'b0;
    endtask

    task automatic set_src(input int kind, input logic v);
        case (kind)
            0: port_irq[0] = v;
            1: port_irq[IRQ_W-1] = v;
            2: rtt_irq = v;
            3: wdt_ovf = v;
            4: bor = v;
            default: rst_pin_n = ~v;
        endcase
    endtask

    task automatic wait_rst_drop();
        for (int i = 0; i < 50; i++) begin
            if (!rst_req) break;
            tick(1);
        end
        tick(3);
    endtask

    task automatic measure_hold(input int d, input int exp_len);
        int len = 0;
        bor = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == d - 1) bor = 1'b0;
            if (rst_req) len++;
        end
        check("R6", "rst_req length", len, exp_len);
        tick(2);
    endtask

    initial begin
        #2000us;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: state after reset
        check("R1", "enables", {core_en, sys_en, wdt_en, rtt_en}, 4'b1111);
        check("R1", "resume/rst", {resume, rst_req}, 2'b00);

        // Table walk: stop at a depth, then wake through one source.
        for (int v = 0; v < NV; v++) begin
            logic mode, wk, rk;
            int   kind;
            mode = VECS[v][5];
            wk   = VECS[v][4];
            rk   = VECS[v][3];
            kind = int'(VECS[v][2:0]);
            wdt_keep = wk;
            rtt_keep = rk;
            do_stop(mode);
            check(mode ? "R3" : "R2", "stopped enables",
                  {core_en, sys_en, wdt_en, rtt_en},
                  {1'b0, !mode, !mode | wk, !mode | rk});
            set_src(kind, 1'b1);
            tick(3);
            check(kind < 3 ? "R4" : "R5", "woken enables",
                  {core_en, sys_en, wdt_en, rtt_en}, 4'b1111);
            check(kind < 3 ? "R4" : "R5", "resume/rst",
                  {resume, rst_req}, {kind < 3, kind >= 3});
            set_src(kind, 1'b0);
            tick(1);
            if (kind < 3) check("R4", "resume one cycle", resume, 1'b0);
            wait_rst_drop();
        end
        wdt_keep = 1'b0;
        rtt_keep = 1'b0;

        // R7: port interrupt synchronized in the same cycle as the stop request
        port_irq[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_stop(1'b1);
        check("R7", "cancelled enables", {core_en, sys_en}, 2'b11);
        check("R7", "no resume", resume, 1'b0);
        port_irq[3] = 1'b0;
        tick(4);
        check("R7", "still running", {core_en, sys_en, resume}, 3'b110);

        // R8: a deep request during a light stop has no effect
        do_stop(1'b0);
        do_stop(1'b1);
        tick(2);
        check("R8", "sys stays on", {core_en, sys_en}, 2'b01);
        rtt_irq = 1'b1;
        tick(3);
        check("R8", "resume after ignored request", {resume, core_en}, 2'b11);
        rtt_irq = 1'b0;
        tick(4);

        // R9: reset and resume sources together during a deep stop
        do_stop(1'b1);
        port_irq[0] = 1'b1;
        bor = 1'b1;
        tick(3);
        check("R9", "resume/rst", {resume, rst_req}, 2'b01);
        port_irq = '0;
        bor = 1'b0;
        wait_rst_drop();

        // R10: resume sources while running
        begin
            logic seen = 1'b0;
            logic all_on = 1'b1;
            port_irq[5] = 1'b1;
            rtt_irq = 1'b1;
            tick(1);
            port_irq[5] = 1'b0;
            rtt_irq = 1'b0;
            for (int i = 0; i < 6; i++) begin
                seen   = seen | resume;
                all_on = all_on & core_en & sys_en;
                tick(1);
            end
            check("R10", "no resume while running", seen, 1'b0);
            check("R10", "enables on", all_on, 1'b1);
        end

        // R6: hold length for a short and a long reset source
        measure_hold(1, HOLD);
        measure_hold(5, 5 + HOLD - 1);

        // R5: reset source while running, via the pin
        rst_pin_n = 1'b0;
        tick(3);
        check("R5", "pin reset while running", {rst_req, resume}, 2'b10);
        rst_pin_n = 1'b1;
        wait_rst_drop();
        check("R5", "reset released", rst_req, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule